// File: doc/BRIEF.md
# 8-bit Arithmetic Unit with Status Flags

This block computes one 8-bit arithmetic or logic result per cycle from two operands and an operation code. It also keeps an 8-bit status register. Each operation produces a candidate status byte from the current one. The block updates only the flags that belong to that operation and copies every other bit across unchanged. When the operation strobe is high, the candidate byte is written into the status register on the next rising clock edge.

The status byte carries, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. The block never changes I or T. Something outside the block decides where a result goes. Compare operations still present their difference on `result`; the surrounding logic is expected not to write it back.

The operations are:
- add with carry;
- compare and subtract forms, with and without a carry (borrow) input;
- increment;
- two's-complement negate;
- logical shift right;
- rotate right through carry;
- nibble swap.

Top module: `alu8_flag_unit`

## Requirements
- R1: The status register resets to 0x00 on an active-low `rstN`. While `opValid` is low, the status register keeps its value across clock edges.
- R2: With `opValid` high, the status register takes the value of `statusNext` on the rising edge. Bits 7 (I) and 6 (T) of `statusNext` always equal those of `status`.
- R3: Code 0 (add with carry) gives `result` = A + B + C. It updates H (carry out of bit 3), S, V (signed overflow), N (bit 7 of the result), Z (result zero) and C (carry out of bit 7). Flag positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R4: Code 2 (compare with immediate) gives `result` = A − B. It updates H (borrow out of bit 3), S, V (signed overflow), N, Z and C (borrow out of bit 7).
- R5: Codes 1 (compare with carry) and 3 (subtract immediate with carry) give `result` = A − B − C and update the same flags as R4. The one difference is Z: it is set only if the result is zero and Z was already set. Otherwise Z is cleared.
- R6: Code 4 (increment) gives `result` = A + 1. It updates S, V (set exactly when the result is 0x80), N and Z. H and C keep their values.
- R7: Code 5 (negate) gives `result` = 0 − A. It updates S, V (set when the result is 0x80), N, Z and C (set when the result is nonzero). H keeps its value.
- R8: Codes 6 (logical shift right, 0 enters bit 7) and 7 (rotate right, the old C enters bit 7) set C from bit 0 of A. N comes from bit 7 of the result, V = N xor C, and Z is updated. H keeps its value.
- R9: Code 8 (nibble swap) gives `result` = {A[3:0], A[7:4]} and leaves the whole status byte unchanged.
- R10: Codes 9 to 15 pass A to `result` and leave the status byte unchanged.
- R11: For every code that updates S, the new S equals the new N xor the new V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Enables the status register update for the current operation |
| opSel | input | 4 | Operation code (0 to 8 defined, others pass A) |
| opA | input | 8 | First operand (destination value) |
| opB | input | 8 | Second operand or immediate |
| result | output | 8 | Combinational operation result |
| statusNext | output | 8 | Status byte the current operation would produce |
| status | output | 8 | Registered status byte |

## Verification
The assertions check several behaviours on every cycle:
- the register holds its value while idle and loads `statusNext` when enabled;
- I and T pass through;
- the sign rule S = N xor V holds for every flag-updating operation;
- increment preserves carry;
- swap and undefined codes leave the status unchanged;
- the carry-in compare and subtract forms never raise Z.

The bench scenarios cover what needs exact values. These are the arithmetic results, the exact H, V and C produced by carries and borrows at chosen operand values, and the 0x80 and zero boundaries of increment and negate. They also include the rotate and shift fill bits, and the case where a zero result keeps Z set only because Z was already set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int STAT_W = 8;
  localparam int BIT_I  = 7;
  localparam int BIT_T  = 6;
  localparam int BIT_H  = 5;
  localparam int BIT_S  = 4;
  localparam int BIT_V  = 3;
  localparam int BIT_N  = 2;
  localparam int BIT_Z  = 1;
  localparam int BIT_C  = 0;

  localparam logic [STAT_W-1:0] MASK_H = STAT_W'(1) << BIT_H;
  localparam logic [STAT_W-1:0] MASK_S = STAT_W'(1) << BIT_S;
  localparam logic [STAT_W-1:0] MASK_V = STAT_W'(1) << BIT_V;
  localparam logic [STAT_W-1:0] MASK_N = STAT_W'(1) << BIT_N;
  localparam logic [STAT_W-1:0] MASK_Z = STAT_W'(1) << BIT_Z;
  localparam logic [STAT_W-1:0] MASK_C = STAT_W'(1) << BIT_C;

  localparam logic [STAT_W-1:0] MASK_SVNZ    = MASK_S | MASK_V | MASK_N | MASK_Z;
  localparam logic [STAT_W-1:0] MASK_SVNZC   = MASK_SVNZ | MASK_C;
  localparam logic [STAT_W-1:0] MASK_ARITH   = MASK_SVNZC | MASK_H;

  typedef enum logic [3:0] {
    OP_ADDC  = 4'd0,
    OP_CMPC  = 4'd1,
    OP_CMPI  = 4'd2,
    OP_SUBIC = 4'd3,
    OP_INC   = 4'd4,
    OP_NEG   = 4'd5,
    OP_SHR   = 4'd6,
    OP_RORC  = 4'd7,
    OP_SWAP  = 4'd8
  } aluOp_e;

  typedef enum logic [1:0] {
    K_ARITH = 2'd0,
    K_SHIFT = 2'd1,
    K_SWAP  = 2'd2,
    K_PASS  = 2'd3
  } aluKind_e;

  typedef struct packed {
    aluKind_e kind;
    logic     subtract;
    logic     useCarry;
    logic     bIsOne;
    logic     aIsZero;
    logic     keepZ;
    logic     shiftFromCarry;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0]        opSel,
  output aluStrobe_t        strb,
  output logic [STAT_W-1:0] flagMask
);

  aluOp_e opCode;
  assign opCode = aluOp_e'(opSel);

  always_comb begin
    strb = '{kind: K_PASS, subtract: 1'b0, useCarry: 1'b0, bIsOne: 1'b0,
             aIsZero: 1'b0, keepZ: 1'b0, shiftFromCarry: 1'b0};
    flagMask = '0;
    case (opCode)
      OP_ADDC: begin
        strb.kind     = K_ARITH;
        strb.useCarry = 1'b1;
        flagMask      = MASK_ARITH;
      end
      OP_CMPC, OP_SUBIC: begin
        strb.kind     = K_ARITH;
        strb.subtract = 1'b1;
        strb.useCarry = 1'b1;
        strb.keepZ    = 1'b1;
        flagMask      = MASK_ARITH;
      end
      OP_CMPI: begin
        strb.kind     = K_ARITH;
        strb.subtract = 1'b1;
        flagMask      = MASK_ARITH;
      end
      OP_INC: begin
        strb.kind   = K_ARITH;
        strb.bIsOne = 1'b1;
        flagMask    = MASK_SVNZ;
      end
      OP_NEG: begin
        strb.kind     = K_ARITH;
        strb.subtract = 1'b1;
        strb.aIsZero  = 1'b1;
        flagMask      = MASK_SVNZC;
      end
      OP_SHR: begin
        strb.kind = K_SHIFT;
        flagMask  = MASK_SVNZC;
      end
      OP_RORC: begin
        strb.kind           = K_SHIFT;
        strb.shiftFromCarry = 1'b1;
        flagMask            = MASK_SVNZC;
      end
      OP_SWAP: begin
        strb.kind = K_SWAP;
      end
      default: begin
        strb.kind = K_PASS;
      end
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobe_t        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              zeroIn,
  output logic [DATA_W-1:0] result,
  output logic              hOut,
  output logic              sOut,
  output logic              vOut,
  output logic              nOut,
  output logic              zOut,
  output logic              cOut
);

  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;
  localparam int WIDE = DATA_W + 1;

  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;
  logic              cin;
  logic [WIDE-1:0]   wideRes;
  logic [DATA_W-1:0] arithRes;
  logic              arithHalf;
  logic              arithOv;
  logic [DATA_W-1:0] shiftRes;
  logic [DATA_W-1:0] swapRes;
  logic              la;
  logic              lb;
  logic              lr;

  assign lhs = strb.aIsZero ? '0 : opA;
  assign rhs = strb.aIsZero ? opA : (strb.bIsOne ? DATA_W'(1) : opB);
  assign cin = strb.useCarry & carryIn;

  always_comb begin
    if (strb.subtract) begin
      wideRes = {1'b0, lhs} - {1'b0, rhs} - WIDE'(cin);
    end else begin
      wideRes = {1'b0, lhs} + {1'b0, rhs} + WIDE'(cin);
    end
  end

  assign arithRes = wideRes[DATA_W-1:0];
  assign la = lhs[HALF-1];
  assign lb = rhs[HALF-1];
  assign lr = arithRes[HALF-1];

  always_comb begin
    if (strb.subtract) begin
      arithHalf = (~la & lb) | (lb & lr) | (lr & ~la);
      arithOv   = (lhs[MSB] ^ rhs[MSB]) & (lhs[MSB] ^ arithRes[MSB]);
    end else begin
      arithHalf = (la & lb) | (lb & ~lr) | (~lr & la);
      arithOv   = ~(lhs[MSB] ^ rhs[MSB]) & (lhs[MSB] ^ arithRes[MSB]);
    end
  end

  assign shiftRes = {strb.shiftFromCarry & carryIn, opA[DATA_W-1:1]};
  assign swapRes  = {opA[HALF-1:0], opA[DATA_W-1:HALF]};

  always_comb begin
    hOut = 1'b0;
    vOut = 1'b0;
    cOut = 1'b0;
    case (strb.kind)
      K_ARITH: begin
        result = arithRes;
        hOut   = arithHalf;
        vOut   = arithOv;
        cOut   = wideRes[DATA_W];
      end
      K_SHIFT: begin
        result = shiftRes;
        cOut   = opA[0];
        vOut   = shiftRes[MSB] ^ opA[0];
      end
      K_SWAP:  result = swapRes;
      default: result = opA;
    endcase
  end

  assign nOut = result[MSB];
  assign zOut = ~|result & (~strb.keepZ | zeroIn);
  assign sOut = nOut ^ vOut;

endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [STAT_W-1:0] statusNext,
  output logic [STAT_W-1:0] status
);

  aluStrobe_t        strb;
  logic [STAT_W-1:0] flagMask;
  logic [STAT_W-1:0] candFlags;
  logic hNew, sNew, vNew, nNew, zNew, cNew;

  alu8_ctrl ctrl_i (
    .opSel    (opSel),
    .strb     (strb),
    .flagMask (flagMask)
  );

  alu8_datapath #(.DATA_W(DATA_W)) dp_i (
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .carryIn (status[BIT_C]),
    .zeroIn  (status[BIT_Z]),
    .result  (result),
    .hOut    (hNew),
    .sOut    (sNew),
    .vOut    (vNew),
    .nOut    (nNew),
    .zOut    (zNew),
    .cOut    (cNew)
  );

  assign candFlags  = {status[BIT_I], status[BIT_T], hNew, sNew, vNew, nNew, zNew, cNew};
  assign statusNext = (candFlags & flagMask) | (status & ~flagMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
    end else if (opValid) begin
      status <= statusNext;
    end
  end

  logic isSub;
  assign isSub = (opSel == 4'd1) || (opSel == 4'd3);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(status)); // R1

  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> status == $past(statusNext)); // R2

  AST_IT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    statusNext[7:6] == status[7:6]); // R2

  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (opSel <= 4'd7) |-> statusNext[BIT_S] == (statusNext[BIT_N] ^ statusNext[BIT_V])); // R11

  AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (isSub && !status[BIT_Z]) |-> !statusNext[BIT_Z]); // R5

  AST_INC_KEEPS_C: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 4'd4) |-> (statusNext[BIT_C] == status[BIT_C] && statusNext[BIT_H] == status[BIT_H])); // R6

  AST_SWAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 4'd8) |-> statusNext == status); // R9

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= 4'd9) |-> (statusNext == status && result == opA)); // R10

endmodule

// File: tb/alu8_flag_unit_tb_top.sv
module alu8_flag_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opSel = 4'd0;
  logic [7:0] opA = 8'd0;
  logic [7:0] opB = 8'd0;
  logic [7:0] result;
  logic [7:0] statusNext;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  alu8_flag_unit dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opSel      (opSel),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .statusNext (statusNext),
    .status     (status)
  );

  task automatic checkVal(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] expRes, input logic [7:0] expStat, input string tag);
    @(negedge clk);
    opSel = op; opA = a; opB = b; opValid = 1'b1;
    #1;
    checkVal({tag, " result"}, result, expRes);
    checkVal({tag, " statusNext"}, statusNext, expStat);
    @(negedge clk);
    opValid = 1'b0;
    checkVal({tag, " status"}, status, expStat);
  endtask

  // C=1 with H,S,N: compare 0 against 1 -> 0x35
  task automatic presetCarry();
    doOp(4'd2, 8'h00, 8'h01, 8'hFF, 8'h35, "R4 preset cmpi 0-1");
  endtask

  // all flags clear: compare 1 against 0 -> 0x00
  task automatic presetClear();
    doOp(4'd2, 8'h01, 8'h00, 8'h01, 8'h00, "R4 preset cmpi 1-0");
  endtask

  task automatic testReset();
    rstN = 1'b0;
    #12;
    checkVal("R1 reset status", status, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testIdleHold();
    presetCarry();
    @(negedge clk);
    opSel = 4'd2; opA = 8'h05; opB = 8'h01; opValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkVal("R1 idle hold", status, 8'h35);
  endtask

  task automatic testAdd();
    presetCarry();
    doOp(4'd0, 8'd10, 8'd20, 8'd31, 8'h00, "R3 addc 10+20+1");
    presetCarry();
    doOp(4'd0, 8'd10, 8'd245, 8'd0, 8'h23, "R3 addc 10+245+1");
    presetClear();
    doOp(4'd0, 8'h7F, 8'h01, 8'h80, 8'h2C, "R3 R11 addc overflow");
  endtask

  task automatic testCompare();
    presetClear();
    doOp(4'd2, 8'h08, 8'h09, 8'hFF, 8'h35, "R4 cmpi 8-9");
    doOp(4'd2, 8'h80, 8'h01, 8'h7F, 8'h38, "R4 R11 cmpi signed overflow");
  endtask

  task automatic testCarrySub();
    presetCarry();
    doOp(4'd1, 8'h00, 8'h00, 8'hFF, 8'h35, "R5 cmpc 0-0-1");
    presetCarry();
    doOp(4'd3, 8'h03, 8'h03, 8'hFF, 8'h35, "R5 subic 3-3-1");
    doOp(4'd2, 8'h05, 8'h05, 8'h00, 8'h02, "R4 cmpi equal sets Z");
    doOp(4'd1, 8'h07, 8'h07, 8'h00, 8'h02, "R5 cmpc zero keeps Z");
    presetCarry();
    doOp(4'd1, 8'h01, 8'h00, 8'h00, 8'h00, "R5 cmpc zero with Z clear");
  endtask

  task automatic testInc();
    presetClear();
    doOp(4'd4, 8'h7F, 8'h00, 8'h80, 8'h0C, "R6 inc 0x7F");
    doOp(4'd4, 8'hFF, 8'h00, 8'h00, 8'h02, "R6 inc 0xFF");
    presetCarry();
    doOp(4'd4, 8'h10, 8'h00, 8'h11, 8'h21, "R6 inc keeps H C");
  endtask

  task automatic testNeg();
    presetClear();
    doOp(4'd5, 8'h56, 8'h00, 8'hAA, 8'h15, "R7 neg 0x56");
    doOp(4'd5, 8'h00, 8'h00, 8'h00, 8'h02, "R7 neg 0x00");
    doOp(4'd5, 8'h80, 8'h00, 8'h80, 8'h0D, "R7 neg 0x80");
  endtask

  task automatic testShift();
    presetClear();
    doOp(4'd6, 8'h45, 8'h00, 8'h22, 8'h19, "R8 shr 0x45");
    presetClear();
    doOp(4'd7, 8'h11, 8'h00, 8'h08, 8'h19, "R8 ror 0x11 C=0");
    presetCarry();
    doOp(4'd7, 8'h02, 8'h00, 8'h81, 8'h2C, "R8 ror 0x02 C=1");
    presetCarry();
    doOp(4'd6, 8'h01, 8'h00, 8'h00, 8'h3B, "R8 shr to zero");
  endtask

  task automatic testQuiet();
    presetCarry();
    doOp(4'd8, 8'hA5, 8'h00, 8'h5A, 8'h35, "R9 swap 0xA5");
    doOp(4'd15, 8'h3C, 8'h99, 8'h3C, 8'h35, "R10 undefined code 15");
    doOp(4'd9, 8'h00, 8'h00, 8'h00, 8'h35, "R10 undefined code 9 zero");
    checkVal("R2 I T stay clear", status & 8'hC0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testIdleHold();
    testAdd();
    testCompare();
    testCarrySub();
    testInc();
    testNeg();
    testShift();
    testQuiet();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule